// File: doc/BRIEF.md
# Load Exception Priority Resolver

This unit sits in the memory stage of a load/store pipeline. For every load request it looks at three possible problems in the same cycle: the address hits an armed data watchpoint, the address is not a multiple of the access size, or the address lies in no legal region of the physical map. It then reports at most one of them. The address map has two windows, main memory and a device region. Each window is given by a base and a size parameter.

A debug-style write port programs the watchpoint. It writes a compare address and an arm bit together. When more than one problem is present, the watchpoint wins. Misalignment comes next, and the access fault is reported only when nothing else applies.

All outputs are registered. The trap strobe, cause and trap value appear exactly one clock after the request. When no trap is reported, the cause and trap value read zero.

Top module: `load_trap_prio`

## Requirements
- R1: While rstN is low, and on the first cycle after its release, trapValid, trapCause and trapVal are all zero, and the watchpoint is disarmed.
- R2: reqSize encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A load is misaligned when reqAddr modulo the width is nonzero.
- R3: A load is legal when its start address satisfies MEM_BASE <= addr < MEM_BASE+MEM_SIZE or DEV_BASE <= addr < DEV_BASE+DEV_SIZE. Any other address is an access fault.
- R4: When several conditions hold at once, only one is reported. The watchpoint hit is chosen first, then misalignment, then the access fault.
- R5: trapCause is 3 for a watchpoint hit, 4 for a misaligned load and 5 for an access fault.
- R6: When a trap is reported, trapVal carries the request's reqAddr.
- R7: A watchpoint hit occurs only when the watchpoint is armed and reqAddr equals the compare value exactly. A write with wpWrEn high loads wpWrData and wpWrArm, and takes effect from the next cycle.
- R8: trapValid is high for exactly the one cycle after a faulting request. A request with no fault, or a cycle with reqValid low, produces trapValid = 0 with trapCause and trapVal both zero.
- R9: A misaligned 4-byte load to 0x100004001 that matches the armed watchpoint reports cause 3, not 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request strobe |
| reqAddr | input | AW | Load virtual address |
| reqSize | input | 2 | Log2 of the access width in bytes |
| wpWrEn | input | 1 | Watchpoint write strobe |
| wpWrData | input | AW | Watchpoint compare address |
| wpWrArm | input | 1 | Watchpoint arm bit written with the address |
| trapValid | output | 1 | One-cycle trap pulse |
| trapCause | output | 4 | Cause code of the reported trap |
| trapVal | output | AW | Faulting address |

## Verification
The bench sweeps every access size against every low-nibble offset. Each combination is placed in main memory, in the device region and in an unmapped range. This separates the alignment masks per size and shows which faults overlap. Every combination is also run three ways: with the watchpoint disarmed, armed on the exact address, and armed on a neighbouring address. This shows that the watchpoint overrides both other faults, and only on an exact armed match. Addresses at the window edges check the inclusive base and the exclusive end of each range. An idle cycle after every request checks that the pulse lasts one cycle and that the outputs then read zero.

// File: rtl/load_trap_pkg.sv
package load_trap_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK   = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALGN = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS  = 4'd5;

  typedef struct packed {
    logic bpHit;
    logic misal;
    logic accFault;
  } flags_t;

  typedef struct packed {
    logic fire;
    logic selBp;
    logic selMis;
    logic selAcc;
  } strb_t;
endpackage

// File: rtl/load_trap_dp.sv
module load_trap_dp
  import load_trap_pkg::*;
#(
  parameter int AW = 40,
  parameter longint unsigned MEM_BASE = 64'h8000_0000,
  parameter longint unsigned MEM_SIZE = 64'h1000_0000,
  parameter longint unsigned DEV_BASE = 64'h1000_0000,
  parameter longint unsigned DEV_SIZE = 64'h0000_1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [AW-1:0]      reqAddr,
  input  logic [1:0]         reqSize,
  input  logic               wpWrEn,
  input  logic [AW-1:0]      wpWrData,
  input  logic               wpWrArm,
  input  strb_t              strb,
  output flags_t             flags,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [AW-1:0]      trapVal
);
  localparam logic [AW:0] MEM_LO = (AW+1)'(MEM_BASE);
  localparam logic [AW:0] MEM_HI = (AW+1)'(MEM_BASE + MEM_SIZE);
  localparam logic [AW:0] DEV_LO = (AW+1)'(DEV_BASE);
  localparam logic [AW:0] DEV_HI = (AW+1)'(DEV_BASE + DEV_SIZE);

  logic [AW-1:0] wpAddr;
  logic          wpArmed;
  logic [2:0]    lowMask;
  logic [AW:0]   addrExt;
  logic          inMem;
  logic          inDev;

  // watchpoint register, loaded through the write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpAddr  <= '0;
      wpArmed <= 1'b0;
    end else if (wpWrEn) begin
      wpAddr  <= wpWrData;
      wpArmed <= wpWrArm;
    end
  end

  // condition detection
  always_comb begin
    lowMask  = (3'd1 << reqSize) - 3'd1;
    addrExt  = {1'b0, reqAddr};
    inMem    = (addrExt >= MEM_LO) && (addrExt < MEM_HI);
    inDev    = (addrExt >= DEV_LO) && (addrExt < DEV_HI);
    flags.bpHit    = wpArmed && (reqAddr == wpAddr);
    flags.misal    = |(reqAddr[2:0] & lowMask);
    flags.accFault = !(inMem || inDev);
  end

  // registered trap payload, zero when nothing is reported
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapCause <= '0;
      trapVal   <= '0;
    end else if (strb.fire) begin
      trapVal <= reqAddr;
      if (strb.selBp)       trapCause <= CAUSE_BREAK;
      else if (strb.selMis) trapCause <= CAUSE_MISALGN;
      else                  trapCause <= CAUSE_ACCESS;
    end else begin
      trapCause <= '0;
      trapVal   <= '0;
    end
  end

  // R6
  val_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> trapVal == $past(reqAddr));

  // R5
  cause_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selMis |=> trapCause == 4'd4);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> (trapCause == '0) && (trapVal == '0));
endmodule

// File: rtl/load_trap_ctrl.sv
module load_trap_ctrl
  import load_trap_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  flags_t flags,
  output strb_t  strb,
  output logic   trapValid
);
  // fixed priority: watchpoint, then alignment, then legality
  always_comb begin
    strb.selBp  = reqValid && flags.bpHit;
    strb.selMis = reqValid && !flags.bpHit && flags.misal;
    strb.selAcc = reqValid && !flags.bpHit && !flags.misal && flags.accFault;
    strb.fire   = strb.selBp || strb.selMis || strb.selAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapValid <= 1'b0;
    else       trapValid <= strb.fire;
  end

  // R4
  single_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selBp, strb.selMis, strb.selAcc}));

  // R4
  bp_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && flags.bpHit) |-> strb.selBp);

  // R8
  trap_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> $past(reqValid));

  // R8
  no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && flags == '0) |=> !trapValid);
endmodule

// File: rtl/load_trap_prio.sv
module load_trap_prio
  import load_trap_pkg::*;
#(
  parameter int AW = 40,
  parameter longint unsigned MEM_BASE = 64'h8000_0000,
  parameter longint unsigned MEM_SIZE = 64'h1000_0000,
  parameter longint unsigned DEV_BASE = 64'h1000_0000,
  parameter longint unsigned DEV_SIZE = 64'h0000_1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic          wpWrEn,
  input  logic [AW-1:0] wpWrData,
  input  logic          wpWrArm,
  output logic          trapValid,
  output logic [3:0]    trapCause,
  output logic [AW-1:0] trapVal
);
  flags_t flags;
  strb_t  strb;

  load_trap_dp #(
    .AW(AW), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE),
    .DEV_BASE(DEV_BASE), .DEV_SIZE(DEV_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqSize(reqSize),
    .wpWrEn(wpWrEn), .wpWrData(wpWrData), .wpWrArm(wpWrArm),
    .strb(strb), .flags(flags), .trapCause(trapCause), .trapVal(trapVal)
  );

  load_trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .flags(flags),
    .strb(strb), .trapValid(trapValid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !trapValid && trapCause == '0);
endmodule

// File: tb/load_trap_prio_tb.sv
module load_trap_prio_tb;
  localparam int AW = 40;
  localparam longint unsigned MB = 64'h8000_0000, MS = 64'h1000_0000;
  localparam longint unsigned DB = 64'h1000_0000, DS = 64'h0000_1000;

  logic clk = 0, rstN = 0, reqValid = 0, wpWrEn = 0, wpWrArm = 0;
  logic [AW-1:0] reqAddr = '0, wpWrData = '0;
  logic [1:0] reqSize = '0;
  logic trapValid;
  logic [3:0] trapCause;
  logic [AW-1:0] trapVal;
  int checks = 0, errors = 0;
  logic mArm = 0;
  logic [AW-1:0] mWp = '0;

  always #10 clk = ~clk;

  load_trap_prio #(.AW(AW), .MEM_BASE(MB), .MEM_SIZE(MS), .DEV_BASE(DB), .DEV_SIZE(DS)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .wpWrEn(wpWrEn), .wpWrData(wpWrData), .wpWrArm(wpWrArm),
    .trapValid(trapValid), .trapCause(trapCause), .trapVal(trapVal));

  task automatic check(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expCause(input longint unsigned a, input int sz);
    bit bp, mis, legal;
    bp = mArm && (a == longint'(mWp));
    mis = (a % (64'd1 << sz)) != 0;
    legal = (a >= MB && a < MB + MS) || (a >= DB && a < DB + DS);
    if (bp) return 3;
    if (mis) return 4;
    if (!legal) return 5;
    return 0;
  endfunction

  task automatic setWp(input longint unsigned v, input bit arm);
    @(negedge clk);
    wpWrEn = 1; wpWrData = AW'(v); wpWrArm = arm;
    @(negedge clk);
    wpWrEn = 0;
    mWp = AW'(v); mArm = arm;
  endtask

  task automatic doReq(input longint unsigned a, input int sz, input string tag);
    int ec;
    ec = expCause(a, sz);
    @(negedge clk);
    reqValid = 1; reqAddr = AW'(a); reqSize = 2'(sz);
    @(negedge clk);
    reqValid = 0;
    check(trapValid == (ec != 0), {tag, " R8 valid"}, trapValid, ec != 0);
    check(trapCause == 4'(ec), {tag, " R4 R5 cause"}, trapCause, ec);
    check(trapVal == (ec != 0 ? AW'(a) : '0), {tag, " R6 tval"}, trapVal, ec != 0 ? a : 0);
    @(negedge clk);
    check(!trapValid && trapCause == 0 && trapVal == 0, {tag, " R8 idle"}, trapValid, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned bases[3];
    bases[0] = MB + 64'h40; bases[1] = DB + 64'h40; bases[2] = 64'h1_0000_4000;
    // R1: outputs quiet under reset
    repeat (2) @(negedge clk);
    check(!trapValid && trapCause == 0 && trapVal == 0, "R1 in reset", trapCause, 0);
    rstN = 1;
    @(negedge clk);
    check(!trapValid && trapCause == 0 && trapVal == 0, "R1 after reset", trapCause, 0);
    // R7: disarmed after reset, so an unmapped aligned load is only an access fault
    doReq(64'h0, 0, "R7 reset disarmed");
    // R9: the specific case
    setWp(64'h1_0000_4001, 1);
    doReq(64'h1_0000_4001, 2, "R9 wp over misalign");
    // R2 R3 R4 R7 sweep
    for (int r = 0; r < 3; r++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 16; off++)
          for (int w = 0; w < 3; w++) begin
            longint unsigned a;
            a = bases[r] + longint'(off);
            if (w == 0) setWp(a, 0);
            else if (w == 1) setWp(a, 1);
            else setWp(a + 1, 1);
            doReq(a, sz, $sformatf("R2 R3 R7 r%0d s%0d o%0d w%0d", r, sz, off, w));
          end
    // R3 window edges
    setWp(0, 0);
    doReq(MB, 3, "R3 mem base");
    doReq(MB - 1, 0, "R3 below mem");
    doReq(MB + MS - 1, 0, "R3 mem last");
    doReq(MB + MS, 0, "R3 mem end");
    doReq(DB, 3, "R3 dev base");
    doReq(DB + DS - 1, 0, "R3 dev last");
    doReq(DB + DS, 0, "R3 dev end");
    // R7: disarm write removes the hit
    setWp(64'h1_0000_4001, 0);
    doReq(64'h1_0000_4001, 2, "R7 disarmed misalign");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule